// File: doc/BRIEF.md
# SIMT Warp Operand Collector Slice

This block is a small single-instruction, multiple-thread execution slice. It takes register-to-register instructions for warps of scalar threads. A warp is wider than the lane array, so each instruction is executed in passes over the lanes. Every warp has its own bank of architectural registers. Because of this, switching between warps costs nothing, and two warps can read source operands in the same cycle without getting in each other's way.

Each warp has one collector entry. The first source register is read in the cycle the instruction is accepted, and the second source is read in the next cycle. Each read vector is stored in the entry, and a per-operand valid bit records that it has arrived. Once both operands are present, the entry asks for the shared lane array. The entry then runs one half of the warp per cycle and writes the whole destination register back in a single cycle. In that writeback cycle the entry becomes free again. An instruction for the same warp that is accepted in that cycle sees the new value through a write-to-read bypass. A separate port lets a host preload individual register elements and read any element back.

Top module: `simt_warp_slice`

## Requirements
- R1: After reset, every element of every register of every warp reads 0, done_o is low, and iss_ready_o is high for every warp.
- R2: Opcode 2'b00 writes rs1 + rs2, modulo 2^32, to rd for every thread of the warp.
- R3: Opcode 2'b01 writes rs1 - rs2, modulo 2^32, to rd for every thread of the warp.
- R4: Opcode 2'b10 copies rs1 to rd for every thread, and the rs2 value has no effect on the result.
- R5: Opcode 2'b11 leaves every register unchanged but still produces a done pulse for its warp.
- R6: With no contention, if an instruction is accepted at clock edge k, then done_o is high with done_warp_o equal to its warp in the cycle that follows edge k+5. The destination value is readable on the debug port in that same cycle. Two cycles of operand reads come first, followed by one cycle per 16-thread pass.
- R7: iss_ready_o for a warp stays low while that warp's entry holds an instruction, and it rises in that entry's writeback cycle. An instruction for the other warp can be accepted in the cycle straight after an acceptance.
- R8: If warp 0 is accepted at edge k and warp 1 at edge k+1, their done pulses follow edges k+5 and k+7. done_o is never high in two consecutive cycles.
- R9: An instruction accepted in the writeback cycle of the previous instruction of the same warp, with rs1 equal to the previous rd, reads the newly written value.
- R10: Instructions of one warp never change any register of another warp, even when both use the same register indices.
- R11: A preload writes exactly one 32-bit element, selected by warp, register and thread, and the debug port returns it combinationally from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Instruction offered |
| iss_ready_o | output | 1 | The entry of the warp selected by iss_warp_i can accept an instruction |
| iss_warp_i | input | 1 | Warp id of the offered instruction |
| iss_op_i | input | 2 | Opcode: 00 add, 01 sub, 10 pass rs1, 11 no-op |
| iss_rd_i | input | 3 | Destination register |
| iss_rs1_i | input | 3 | First source register |
| iss_rs2_i | input | 3 | Second source register |
| pl_we_i | input | 1 | Preload write enable |
| pl_warp_i | input | 1 | Preload warp |
| pl_reg_i | input | 3 | Preload register |
| pl_thread_i | input | 5 | Preload thread |
| pl_data_i | input | 32 | Preload value |
| dbg_warp_i | input | 1 | Debug read warp |
| dbg_reg_i | input | 3 | Debug read register |
| dbg_thread_i | input | 5 | Debug read thread |
| dbg_data_o | output | 32 | Debug read value |
| done_o | output | 1 | Writeback completion pulse |
| done_warp_o | output | 1 | Warp of the completed instruction |

## Verification
Any of the following internal faults shows up as a wrong 32-bit element on the debug port as soon as the done pulse of the affected instruction arrives: operands captured in the wrong pass, the wrong half of the buffer overwritten, or a collector entry starting execution before its second operand is in. Faults in the arbitration or the pass counter move the done pulse away from the cycle fixed in R6 or R8, or stall iss_ready_o past the writeback cycle. A broken bypass leaves the old value in the dependent destination. Writes that leak between banks show up in the full register-file comparison made at the end of the run.

// File: rtl/simt_pkg.sv
package simt_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_PASS = 2'b10,
    OP_RSVD = 2'b11
  } simt_op_e;

  typedef enum logic [2:0] {
    SL_FREE,
    SL_RD2,
    SL_WAIT,
    SL_EXEC,
    SL_WB
  } slot_state_e;

endpackage

// File: rtl/simt_reg_bank.sv
module simt_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int WARP     = 32,
  parameter int DATA_W   = 32,
  localparam int RID_W   = $clog2(NUM_REGS),
  localparam int VEC_W   = WARP * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [RID_W-1:0] wr_reg_i,
  input  logic [WARP-1:0]  wr_mask_i,
  input  logic [VEC_W-1:0] wr_vec_i,
  input  logic [RID_W-1:0] rd_reg_i,
  output logic [VEC_W-1:0] rd_vec_o,
  input  logic [RID_W-1:0] dbg_reg_i,
  output logic [VEC_W-1:0] dbg_vec_o
);

  logic [VEC_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
    end else if (wr_en_i) begin
      for (int t = 0; t < WARP; t++)
        if (wr_mask_i[t]) mem_q[wr_reg_i][t*DATA_W +: DATA_W] <= wr_vec_i[t*DATA_W +: DATA_W];
    end
  end

  // write-to-read bypass, per thread element
  always_comb begin
    rd_vec_o = mem_q[rd_reg_i];
    if (wr_en_i && (wr_reg_i == rd_reg_i)) begin
      for (int t = 0; t < WARP; t++)
        if (wr_mask_i[t]) rd_vec_o[t*DATA_W +: DATA_W] = wr_vec_i[t*DATA_W +: DATA_W];
    end
  end

  assign dbg_vec_o = mem_q[dbg_reg_i];

  a_r9_fwd_matches_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_reg_i == rd_reg_i)) |=> (mem_q[$past(rd_reg_i)] == $past(rd_vec_o)));

endmodule

// File: rtl/simt_lane_array.sv
module simt_lane_array
  import simt_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int DATA_W = 32,
  localparam int HALF_W = LANES * DATA_W
) (
  input  simt_op_e          op_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [HALF_W-1:0] res_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] a, b, r;
    assign a = a_i[l*DATA_W +: DATA_W];
    assign b = b_i[l*DATA_W +: DATA_W];
    always_comb begin
      unique case (op_i)
        OP_ADD:  r = a + b;
        OP_SUB:  r = a - b;
        default: r = a;
      endcase
    end
    assign res_o[l*DATA_W +: DATA_W] = r;
  end

endmodule

// File: rtl/simt_slot.sv
module simt_slot
  import simt_pkg::*;
#(
  parameter int WARP     = 32,
  parameter int LANES    = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int RID_W   = $clog2(NUM_REGS),
  localparam int VEC_W   = WARP * DATA_W,
  localparam int HALF_W  = LANES * DATA_W,
  localparam int PASSES  = WARP / LANES,
  localparam int PASS_W  = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  simt_op_e          op_i,
  input  logic [RID_W-1:0]  rd_i,
  input  logic [RID_W-1:0]  rs1_i,
  input  logic [RID_W-1:0]  rs2_i,
  input  logic              grant_i,
  output logic [RID_W-1:0]  rd_addr_o,
  input  logic [VEC_W-1:0]  rd_vec_i,
  input  logic [HALF_W-1:0] res_half_i,
  output logic [HALF_W-1:0] a_half_o,
  output logic [HALF_W-1:0] b_half_o,
  output simt_op_e          op_o,
  output logic              free_o,
  output logic              req_o,
  output logic              exec_o,
  output logic              busy_o,
  output logic              wb_o,
  output logic              wb_we_o,
  output logic [RID_W-1:0]  wb_reg_o,
  output logic [VEC_W-1:0]  wb_vec_o
);

  slot_state_e       state_q;
  simt_op_e          op_q;
  logic [RID_W-1:0]  rd_q, rs2_q;
  logic [1:0]        opnd_vld_q;
  logic [VEC_W-1:0]  buf_a_q, buf_b_q;
  logic [PASS_W-1:0] pass_q;
  logic              last_pass;

  assign last_pass = (pass_q == PASS_W'(PASSES - 1));
  assign rd_addr_o = (state_q == SL_RD2) ? rs2_q : rs1_i;
  assign free_o    = (state_q == SL_FREE) || (state_q == SL_WB);
  assign req_o     = (state_q == SL_RD2) || (state_q == SL_WAIT);
  assign exec_o    = (state_q == SL_EXEC);
  assign busy_o    = exec_o && !last_pass;
  assign wb_o      = (state_q == SL_WB);
  assign wb_we_o   = wb_o && (op_q != OP_RSVD);
  assign wb_reg_o  = rd_q;
  assign wb_vec_o  = buf_a_q;
  assign op_o      = op_q;
  assign a_half_o  = buf_a_q[pass_q*HALF_W +: HALF_W];
  assign b_half_o  = buf_b_q[pass_q*HALF_W +: HALF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SL_FREE;
      op_q       <= OP_ADD;
      rd_q       <= '0;
      rs2_q      <= '0;
      opnd_vld_q <= '0;
      buf_a_q    <= '0;
      buf_b_q    <= '0;
      pass_q     <= '0;
    end else begin
      unique case (state_q)
        SL_FREE, SL_WB: begin
          if (accept_i) begin
            state_q    <= SL_RD2;
            op_q       <= op_i;
            rd_q       <= rd_i;
            rs2_q      <= rs2_i;
            buf_a_q    <= rd_vec_i;
            opnd_vld_q <= 2'b01;
          end else begin
            state_q    <= SL_FREE;
            opnd_vld_q <= 2'b00;
          end
        end
        SL_RD2: begin
          buf_b_q       <= rd_vec_i;
          opnd_vld_q[1] <= 1'b1;
          pass_q        <= '0;
          state_q       <= grant_i ? SL_EXEC : SL_WAIT;
        end
        SL_WAIT: begin
          pass_q <= '0;
          if (grant_i) state_q <= SL_EXEC;
        end
        SL_EXEC: begin
          // result overwrites the rs1 half already consumed
          buf_a_q[pass_q*HALF_W +: HALF_W] <= res_half_i;
          if (last_pass) state_q <= SL_WB;
          else           pass_q  <= pass_q + 1'b1;
        end
        default: state_q <= SL_FREE;
      endcase
    end
  end

  a_r6_exec_has_opnds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SL_EXEC) |-> (opnd_vld_q == 2'b11));

endmodule

// File: rtl/simt_warp_slice.sv
module simt_warp_slice
  import simt_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int LANES     = 16,
  parameter int NUM_WARPS = 2,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int RID_W    = $clog2(NUM_REGS),
  localparam int TID_W    = $clog2(WARP_SIZE),
  localparam int VEC_W    = WARP_SIZE * DATA_W,
  localparam int HALF_W   = LANES * DATA_W,
  localparam int PASSES   = WARP_SIZE / LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  output logic              iss_ready_o,
  input  logic [WID_W-1:0]  iss_warp_i,
  input  logic [1:0]        iss_op_i,
  input  logic [RID_W-1:0]  iss_rd_i,
  input  logic [RID_W-1:0]  iss_rs1_i,
  input  logic [RID_W-1:0]  iss_rs2_i,
  input  logic              pl_we_i,
  input  logic [WID_W-1:0]  pl_warp_i,
  input  logic [RID_W-1:0]  pl_reg_i,
  input  logic [TID_W-1:0]  pl_thread_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic [WID_W-1:0]  dbg_warp_i,
  input  logic [RID_W-1:0]  dbg_reg_i,
  input  logic [TID_W-1:0]  dbg_thread_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic              done_o,
  output logic [WID_W-1:0]  done_warp_o
);

  logic [NUM_WARPS-1:0] free, req, exec, busy, wb, wb_we, accept, grant;
  logic [RID_W-1:0]     rd_addr [NUM_WARPS];
  logic [RID_W-1:0]     wb_reg  [NUM_WARPS];
  logic [VEC_W-1:0]     rd_vec  [NUM_WARPS];
  logic [VEC_W-1:0]     wb_vec  [NUM_WARPS];
  logic [VEC_W-1:0]     dbg_vec [NUM_WARPS];
  logic [HALF_W-1:0]    a_half  [NUM_WARPS];
  logic [HALF_W-1:0]    b_half  [NUM_WARPS];
  simt_op_e             slot_op [NUM_WARPS];

  logic [HALF_W-1:0] a_sel, b_sel, res_half;
  logic [1:0]        op_bits;
  logic              done_q;
  logic [WID_W-1:0]  done_warp_q, done_warp_d;
  logic [VEC_W-1:0]  dbg_sel;

  assign iss_ready_o = free[iss_warp_i];

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    logic             bank_we;
    logic [RID_W-1:0] bank_reg;
    logic [WARP_SIZE-1:0] bank_mask;
    logic [VEC_W-1:0] bank_vec;
    logic             pl_hit;

    assign accept[g] = iss_valid_i && free[g] && (iss_warp_i == WID_W'(g));
    // writeback owns the write port; a colliding preload is dropped
    assign pl_hit    = pl_we_i && (pl_warp_i == WID_W'(g)) && !wb_we[g];
    assign bank_we   = wb_we[g] || pl_hit;
    assign bank_reg  = wb_we[g] ? wb_reg[g] : pl_reg_i;
    assign bank_mask = wb_we[g] ? {WARP_SIZE{1'b1}} : (WARP_SIZE'(1) << pl_thread_i);
    assign bank_vec  = wb_we[g] ? wb_vec[g] : {WARP_SIZE{pl_data_i}};

    simt_reg_bank #(
      .NUM_REGS(NUM_REGS), .WARP(WARP_SIZE), .DATA_W(DATA_W)
    ) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_we),
      .wr_reg_i  (bank_reg),
      .wr_mask_i (bank_mask),
      .wr_vec_i  (bank_vec),
      .rd_reg_i  (rd_addr[g]),
      .rd_vec_o  (rd_vec[g]),
      .dbg_reg_i (dbg_reg_i),
      .dbg_vec_o (dbg_vec[g])
    );

    simt_slot #(
      .WARP(WARP_SIZE), .LANES(LANES), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
    ) slot_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .accept_i   (accept[g]),
      .op_i       (simt_op_e'(iss_op_i)),
      .rd_i       (iss_rd_i),
      .rs1_i      (iss_rs1_i),
      .rs2_i      (iss_rs2_i),
      .grant_i    (grant[g]),
      .rd_addr_o  (rd_addr[g]),
      .rd_vec_i   (rd_vec[g]),
      .res_half_i (res_half),
      .a_half_o   (a_half[g]),
      .b_half_o   (b_half[g]),
      .op_o       (slot_op[g]),
      .free_o     (free[g]),
      .req_o      (req[g]),
      .exec_o     (exec[g]),
      .busy_o     (busy[g]),
      .wb_o       (wb[g]),
      .wb_we_o    (wb_we[g]),
      .wb_reg_o   (wb_reg[g]),
      .wb_vec_o   (wb_vec[g])
    );
  end

  // lane array is free when nobody is in a non-final pass; lowest warp id wins
  always_comb begin
    grant = '0;
    if (busy == '0) begin
      for (int w = 0; w < NUM_WARPS; w++)
        if (req[w] && (grant == '0)) grant[w] = 1'b1;
    end
  end

  always_comb begin
    a_sel   = '0;
    b_sel   = '0;
    op_bits = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (exec[w]) begin
        a_sel   = a_sel | a_half[w];
        b_sel   = b_sel | b_half[w];
        op_bits = op_bits | slot_op[w];
      end
    end
  end

  simt_lane_array #(.LANES(LANES), .DATA_W(DATA_W)) lanes_i (
    .op_i  (simt_op_e'(op_bits)),
    .a_i   (a_sel),
    .b_i   (b_sel),
    .res_o (res_half)
  );

  always_comb begin
    done_warp_d = '0;
    for (int w = 0; w < NUM_WARPS; w++)
      if (wb[w]) done_warp_d = WID_W'(w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      done_warp_q <= '0;
    end else begin
      done_q      <= |wb;
      done_warp_q <= done_warp_d;
    end
  end

  assign done_o      = done_q;
  assign done_warp_o = done_warp_q;

  assign dbg_sel    = dbg_vec[dbg_warp_i];
  assign dbg_data_o = dbg_sel[dbg_thread_i*DATA_W +: DATA_W];

  a_r6_one_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exec));

  a_r8_one_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wb));

  if (PASSES > 1) begin : g_spacing
    a_r8_done_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
  end

endmodule

// File: tb/simt_warp_slice_tb.sv
module simt_warp_slice_tb_top;

  localparam int NW = 2;
  localparam int NR = 8;
  localparam int WS = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_warp = 1'b0;
  logic [1:0]  iss_op = '0;
  logic [2:0]  iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0;
  logic        pl_we = 1'b0;
  logic        pl_warp = 1'b0;
  logic [2:0]  pl_reg = '0;
  logic [4:0]  pl_thread = '0;
  logic [31:0] pl_data = '0;
  logic        dbg_warp = 1'b0;
  logic [2:0]  dbg_reg = '0;
  logic [4:0]  dbg_thread = '0;
  logic        iss_ready_o, done_o, done_warp_o;
  logic [31:0] dbg_data_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int done_cnt [NW];
  int last_done_cyc [NW];
  int consec_err = 0;
  bit prev_done = 1'b0;
  logic [31:0] exp_rf [NW][NR][WS];

  always #5 clk = ~clk;

  simt_warp_slice dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid), .iss_ready_o(iss_ready_o), .iss_warp_i(iss_warp),
    .iss_op_i(iss_op), .iss_rd_i(iss_rd), .iss_rs1_i(iss_rs1), .iss_rs2_i(iss_rs2),
    .pl_we_i(pl_we), .pl_warp_i(pl_warp), .pl_reg_i(pl_reg), .pl_thread_i(pl_thread),
    .pl_data_i(pl_data),
    .dbg_warp_i(dbg_warp), .dbg_reg_i(dbg_reg), .dbg_thread_i(dbg_thread),
    .dbg_data_o(dbg_data_o),
    .done_o(done_o), .done_warp_o(done_warp_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (rst_ni && done_o) begin
      done_cnt[done_warp_o]++;
      last_done_cyc[done_warp_o] = cyc;
      if (prev_done) consec_err++;
    end
    prev_done = rst_ni && done_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  task automatic read_el(input int w, input int r, input int t, output logic [31:0] v);
    @(negedge clk);
    dbg_warp = w[0]; dbg_reg = r[2:0]; dbg_thread = t[4:0];
    #1 v = dbg_data_o;
  endtask

  task automatic preload(input int w, input int r, input int t, input logic [31:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_warp = w[0]; pl_reg = r[2:0]; pl_thread = t[4:0]; pl_data = d;
    exp_rf[w][r][t] = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  // model: program order per warp, arithmetic from the requirements
  task automatic apply_model(input int w, input int op, input int rd, input int rs1, input int rs2);
    logic [31:0] a [WS];
    logic [31:0] b [WS];
    for (int t = 0; t < WS; t++) begin
      a[t] = exp_rf[w][rs1][t];
      b[t] = exp_rf[w][rs2][t];
    end
    for (int t = 0; t < WS; t++) begin
      case (op)
        0: exp_rf[w][rd][t] = a[t] + b[t];
        1: exp_rf[w][rd][t] = a[t] - b[t];
        2: exp_rf[w][rd][t] = a[t];
        default: ;
      endcase
    end
  endtask

  task automatic do_issue(input bit sync, input int w, input int op, input int rd,
                          input int rs1, input int rs2, output int n_acc);
    if (sync) @(negedge clk);
    iss_valid = 1'b1; iss_warp = w[0]; iss_op = op[1:0];
    iss_rd = rd[2:0]; iss_rs1 = rs1[2:0]; iss_rs2 = rs2[2:0];
    #1;
    while (!iss_ready_o) begin
      @(negedge clk);
      #1;
    end
    n_acc = cyc;
    apply_model(w, op, rd, rs1, rs2);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic wait_done(input int w, input int base, input int n_acc, input int lat,
                           input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      #2;
      if (done_cnt[w] > base) seen = 1'b1;
    end
    chk({req, " done seen"}, 32'(seen), 32'd1);
    chk({req, " done cycle"}, 32'(last_done_cyc[w]), 32'(n_acc + lat));
  endtask

  task automatic check_reg(input int w, input int r, input string req);
    logic [31:0] v;
    for (int t = 0; t < WS; t++) begin
      read_el(w, r, t, v);
      chk(req, v, exp_rf[w][r][t]);
    end
  endtask

  function automatic logic [31:0] pat(input int sel, input int s, input int w, input int t);
    logic [31:0] tt = 32'(t);
    logic [31:0] ww = 32'(w);
    case (s)
      0: return sel == 0 ? 32'hFFFF_FFFF - tt : tt + 32'd1;
      1: return sel == 0 ? tt * 32'h0101_0101 + ww : 32'h8000_0000 >> tt;
      default: return sel == 0 ? (32'h1234_5678 ^ (tt << (t % 24))) + ww * 32'd3
                               : 32'h7FFF_FFFF + tt * 32'd977;
    endcase
  endfunction

  initial begin
    int n0, n1, b0, b1;
    logic [31:0] v;
    for (int w = 0; w < NW; w++) begin
      done_cnt[w] = 0;
      last_done_cyc[w] = -1;
      for (int r = 0; r < NR; r++)
        for (int t = 0; t < WS; t++) exp_rf[w][r][t] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    chk("R1 done_o low", 32'(done_o), 32'd0);
    iss_warp = 1'b0; #1 chk("R1 ready warp0", 32'(iss_ready_o), 32'd1);
    iss_warp = 1'b1; #1 chk("R1 ready warp1", 32'(iss_ready_o), 32'd1);
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) check_reg(w, r, "R1 register zero");

    // R11: single-element preload
    preload(1, 6, 7, 32'hA5A5_5A5A);
    read_el(1, 6, 7, v); chk("R11 preload element", v, 32'hA5A5_5A5A);
    read_el(1, 6, 6, v); chk("R11 neighbour thread", v, 32'h0);
    read_el(1, 6, 8, v); chk("R11 neighbour thread", v, 32'h0);
    read_el(0, 6, 7, v); chk("R11 other warp", v, 32'h0);

    // R2 R3 R4 R5 R6: sweep of opcodes, warps and data patterns
    for (int w = 0; w < NW; w++) begin
      for (int op = 0; op < 4; op++) begin
        for (int s = 0; s < 3; s++) begin
          int rs1 = (op * 3 + s + w) % NR;
          int rs2 = (rs1 + 1 + s) % NR;
          int rd  = (rs1 + 2 + op) % NR;
          string tag;
          case (op)
            0: tag = "R2 add";
            1: tag = "R3 sub";
            2: tag = "R4 pass";
            default: tag = "R5 reserved";
          endcase
          for (int t = 0; t < WS; t++) preload(w, rs1, t, pat(0, s, w, t));
          for (int t = 0; t < WS; t++) preload(w, rs2, t, pat(1, s, w, t));
          b0 = done_cnt[w];
          do_issue(1'b1, w, op, rd, rs1, rs2, n0);
          wait_done(w, b0, n0, 5, "R6 latency");
          check_reg(w, rd, tag);
        end
      end
    end

    // R8 R10 R7: two warps overlapped on the same register indices
    for (int t = 0; t < WS; t++) begin
      preload(0, 1, t, pat(0, 2, 0, t));
      preload(0, 2, t, pat(1, 0, 0, t));
      preload(1, 1, t, pat(1, 1, 1, t));
      preload(1, 2, t, pat(0, 0, 1, t));
    end
    b0 = done_cnt[0];
    b1 = done_cnt[1];
    do_issue(1'b1, 0, 0, 3, 1, 2, n0);
    do_issue(1'b0, 1, 1, 3, 1, 2, n1);
    chk("R7 other warp accepted next cycle", 32'(n1), 32'(n0 + 1));
    wait_done(0, b0, n0, 5, "R8 warp0");
    wait_done(1, b1, n0, 7, "R8 warp1");
    check_reg(0, 3, "R10 warp0 result");
    check_reg(1, 3, "R10 warp1 result");

    // R9 R7: dependent instruction accepted in the writeback cycle
    b0 = done_cnt[0];
    do_issue(1'b1, 0, 0, 5, 1, 2, n0);
    do_issue(1'b0, 0, 2, 6, 5, 0, n1);
    chk("R7 same warp accepted in writeback cycle", 32'(n1), 32'(n0 + 4));
    wait_done(0, b0 + 1, n1, 5, "R9 dependent");
    check_reg(0, 6, "R9 forwarded rs1");
    check_reg(0, 5, "R9 producer");

    // R8: no back-to-back done pulses seen anywhere
    chk("R8 done spacing", 32'(consec_err), 32'd0);

    // R10 R11: full register file against the model
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) check_reg(w, r, "R10 full register file");

    summary();
  end

endmodule